// File: doc/BRIEF.md
# Two-Phase Sequenced Register Datapath

This block is a small datapath of parallel-load registers, steered by a Moore control unit. Four working registers (A, B, C, D) form a chain. A two-input selector feeds A from either the data input or the ALU result. An address register is loaded through a second two-input selector from A or B. A 2-bit-op ALU takes A as X and B as Y and reports zero, negative and carry flags.

The control unit is clocked on the rising edge. Its registered outputs are the selector choices, the ALU operation, the load strobes and the memory-request strobes. The data registers capture on the falling edge, so the selector and ALU paths settle within the high phase before any register loads.

A `start` pulse in the idle state launches a fixed microsequence:
- load A from the input;
- load A again while B takes the old A;
- subtract B from A while C takes B;
- branch on whether A AND B is zero;
- load the address register;
- move C into D;
- wait in a memory-request state until `ack` is seen;
- pulse `done` and return to idle.

Top module: `seqpath_top`

## Requirements
- R1: The ALU computes X+Y for op 00, X−Y for op 01, X AND Y for op 10 and NOT X for op 11, modulo 2^W. Its flags are: zero when the result is 0; negative equal to result bit W−1; carry equal to the carry-out for add, 1 when X ≥ Y for subtract, and 0 for the other ops. In idle the op is add, so the flags show A+B.
- R2: A register whose load strobe is low keeps its value across a falling edge, including in the idle state.
- R3: Control outputs change only after a rising edge. A register loaded in a state takes its new value at the falling edge inside that state, not at the rising edge that entered it.
- R4: When several registers load in one state, each captures its source's value from before that edge. In the second state, B gets the first operand while A gets the second.
- R5: Data reaches D only through B and then C (B←A, C←B, D←C), so D ends each run holding the first operand.
- R6: The address register takes A when its selector is 0 and B when it is 1.
- R7: After the subtract, if A AND B is zero, the sequence inverts A and then loads the address register from A. Otherwise it loads the address register from B. The zero path is one cycle longer.
- R8: In the memory-request state, chip-enable = 1, read/write = 1 and the address output enable = 1, and no register loads. The unit stays in this state while `ack` = 0 and leaves it on the first rising edge that sees `ack` = 1.
- R9: The address output enable is high only in the memory-request state. When it is low the address bus is high-impedance.
- R10: A synchronous active-high `rst` returns the unit to idle, with all strobes low and the output enable off, and clears all data registers to 0.
- R11: `done` is high for exactly one cycle, right after the memory-request state ends, and the unit is idle on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; control on rising edge, data on falling edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches the microsequence from idle |
| din | input | W | Data input for register A |
| ack | input | 1 | Memory acknowledge |
| reg_a | output | W | Register A |
| reg_b | output | W | Register B |
| reg_c | output | W | Register C |
| reg_d | output | W | Register D |
| flag_zero | output | 1 | ALU result is zero |
| flag_neg | output | 1 | ALU result MSB |
| flag_carry | output | 1 | ALU carry / no-borrow |
| mem_ce | output | 1 | Memory chip-enable |
| mem_rw | output | 1 | Memory read/write (1 = read) |
| addr_oe | output | 1 | Address bus output enable |
| addr_bus | output | W | Address register onto bus, high-Z when disabled |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The assertions check the following on every edge:
- the strobes in the memory-request state and its wait on `ack`;
- that the output enable is confined to that state;
- the one-cycle width of `done`;
- holding of A when unloaded;
- old-value capture into B and D on each falling edge.

The bench sweeps every pair of operands at a 4-bit width. It shows the arithmetic results and the branch outcome with its path length. It also shows the choice of address source, the half-cycle placement of loads and the reset state, none of which a per-edge property pins down.

// File: rtl/seqpath_pkg.sv
package seqpath_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_AND = 2'b10,
        OP_NOT = 2'b11
    } alu_op_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_LD1, ST_LD2, ST_SUB, ST_TEST, ST_INV,
        ST_ADRA, ST_ADRB, ST_MOVD, ST_MEM, ST_DONE
    } state_e;

    typedef struct packed {
        logic    asel;
        logic    msel;
        alu_op_e op;
        logic    ld_a;
        logic    ld_b;
        logic    ld_c;
        logic    ld_d;
        logic    ld_m;
        logic    ce;
        logic    rw;
        logic    m_oe;
        logic    done;
    } ctrl_t;
endpackage

// File: rtl/seqpath_alu.sv
module seqpath_alu
    import seqpath_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  alu_op_e      op,
    output logic [W-1:0] z,
    output logic         zero,
    output logic         neg,
    output logic         carry
);
    localparam int EW = W + 1;

    logic [EW-1:0] ext;

    always_comb begin
        case (op)
            OP_ADD:  ext = {1'b0, x} + {1'b0, y};
            OP_SUB:  ext = {1'b0, x} + {1'b0, ~y} + EW'(1);
            OP_AND:  ext = {1'b0, x & y};
            default: ext = {1'b0, ~x};
        endcase
        z     = ext[W-1:0];
        zero  = (ext[W-1:0] == '0);
        neg   = ext[W-1];
        carry = ext[W];
    end
endmodule

// File: rtl/seqpath_ctrl.sv
module seqpath_ctrl
    import seqpath_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  ack,
    input  logic  alu_zero,
    output ctrl_t ctl
);
    typedef struct packed {
        state_e st;
        ctrl_t  c;
    } fsm_t;

    fsm_t cur_q, nxt_d;

    function automatic ctrl_t decode(state_e s);
        ctrl_t c;
        c = '0;
        case (s)
            ST_LD1:  begin c.ld_a = 1'b1; end
            ST_LD2:  begin c.ld_a = 1'b1; c.ld_b = 1'b1; end
            ST_SUB:  begin c.op = OP_SUB; c.asel = 1'b1; c.ld_a = 1'b1; c.ld_c = 1'b1; end
            ST_TEST: begin c.op = OP_AND; end
            ST_INV:  begin c.op = OP_NOT; c.asel = 1'b1; c.ld_a = 1'b1; end
            ST_ADRA: begin c.msel = 1'b0; c.ld_m = 1'b1; end
            ST_ADRB: begin c.msel = 1'b1; c.ld_m = 1'b1; end
            ST_MOVD: begin c.ld_d = 1'b1; end
            ST_MEM:  begin c.ce = 1'b1; c.rw = 1'b1; c.m_oe = 1'b1; end
            ST_DONE: begin c.done = 1'b1; end
            default: ;
        endcase
        return c;
    endfunction

    always_comb begin
        nxt_d.st = cur_q.st;
        case (cur_q.st)
            ST_IDLE: if (start) nxt_d.st = ST_LD1;
            ST_LD1:  nxt_d.st = ST_LD2;
            ST_LD2:  nxt_d.st = ST_SUB;
            ST_SUB:  nxt_d.st = ST_TEST;
            ST_TEST: nxt_d.st = alu_zero ? ST_INV : ST_ADRB;
            ST_INV:  nxt_d.st = ST_ADRA;
            ST_ADRA: nxt_d.st = ST_MOVD;
            ST_ADRB: nxt_d.st = ST_MOVD;
            ST_MOVD: nxt_d.st = ST_MEM;
            ST_MEM:  if (ack) nxt_d.st = ST_DONE;
            default: nxt_d.st = ST_IDLE;
        endcase
        if (rst) nxt_d.st = ST_IDLE;
        nxt_d.c = decode(nxt_d.st);
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end

    assign ctl = cur_q.c;
endmodule

// File: rtl/seqpath_regs.sv
module seqpath_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    input  logic [W-1:0] alu_z,
    input  logic         asel,
    input  logic         msel,
    input  logic         ld_a,
    input  logic         ld_b,
    input  logic         ld_c,
    input  logic         ld_d,
    input  logic         ld_m,
    output logic [W-1:0] a,
    output logic [W-1:0] b,
    output logic [W-1:0] c,
    output logic [W-1:0] d,
    output logic [W-1:0] m
);
    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] c;
        logic [W-1:0] d;
        logic [W-1:0] m;
    } bank_t;

    bank_t bank_q, bank_d;

    always_comb begin
        bank_d = bank_q;
        if (ld_a) bank_d.a = asel ? alu_z : din;
        if (ld_b) bank_d.b = bank_q.a;
        if (ld_c) bank_d.c = bank_q.b;
        if (ld_d) bank_d.d = bank_q.c;
        if (ld_m) bank_d.m = msel ? bank_q.b : bank_q.a;
        if (rst)  bank_d = '0;
    end

    always_ff @(negedge clk) begin
        bank_q <= bank_d;
    end

    assign a = bank_q.a;
    assign b = bank_q.b;
    assign c = bank_q.c;
    assign d = bank_q.d;
    assign m = bank_q.m;
endmodule

// File: rtl/seqpath_top.sv
module seqpath_top
    import seqpath_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] din,
    input  logic         ack,
    output logic [W-1:0] reg_a,
    output logic [W-1:0] reg_b,
    output logic [W-1:0] reg_c,
    output logic [W-1:0] reg_d,
    output logic         flag_zero,
    output logic         flag_neg,
    output logic         flag_carry,
    output logic         mem_ce,
    output logic         mem_rw,
    output logic         addr_oe,
    output logic [W-1:0] addr_bus,
    output logic         done
);
    ctrl_t        ctl;
    logic [W-1:0] alu_z;
    logic [W-1:0] mar;

    seqpath_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .ack      (ack),
        .alu_zero (flag_zero),
        .ctl      (ctl)
    );

    seqpath_alu #(.W(W)) u_alu (
        .x     (reg_a),
        .y     (reg_b),
        .op    (ctl.op),
        .z     (alu_z),
        .zero  (flag_zero),
        .neg   (flag_neg),
        .carry (flag_carry)
    );

    seqpath_regs #(.W(W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .din   (din),
        .alu_z (alu_z),
        .asel  (ctl.asel),
        .msel  (ctl.msel),
        .ld_a  (ctl.ld_a),
        .ld_b  (ctl.ld_b),
        .ld_c  (ctl.ld_c),
        .ld_d  (ctl.ld_d),
        .ld_m  (ctl.ld_m),
        .a     (reg_a),
        .b     (reg_b),
        .c     (reg_c),
        .d     (reg_d),
        .m     (mar)
    );

    assign mem_ce   = ctl.ce;
    assign mem_rw   = ctl.rw;
    assign addr_oe  = ctl.m_oe;
    assign done     = ctl.done;
    assign addr_bus = ctl.m_oe ? mar : 'z;
endmodule

// File: rtl/seqpath_chk.sv
module seqpath_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         ack,
    input logic         mem_ce,
    input logic         mem_rw,
    input logic         addr_oe,
    input logic         done,
    input logic         ld_a,
    input logic         ld_b,
    input logic         ld_c,
    input logic         ld_d,
    input logic         ld_m,
    input logic [W-1:0] reg_a,
    input logic [W-1:0] reg_b,
    input logic [W-1:0] reg_c,
    input logic [W-1:0] reg_d
);
    AST_MEM_STROBES: assert property (@(posedge clk) disable iff (rst)
        mem_ce |-> (mem_rw && addr_oe && !(ld_a || ld_b || ld_c || ld_d || ld_m))); // R8
    AST_ACK_WAIT: assert property (@(posedge clk) disable iff (rst)
        (mem_ce && !ack) |=> mem_ce); // R8
    AST_OE_ONLY_MEM: assert property (@(posedge clk) disable iff (rst)
        addr_oe |-> mem_ce); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11
    AST_HOLD_A: assert property (@(negedge clk) disable iff (rst)
        !ld_a |=> $stable(reg_a)); // R2
    AST_PAR_B: assert property (@(negedge clk) disable iff (rst)
        ld_b |=> (reg_b == $past(reg_a))); // R4
    AST_CHAIN_D: assert property (@(negedge clk) disable iff (rst)
        ld_d |=> (reg_d == $past(reg_c))); // R5
endmodule

bind seqpath_top seqpath_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ack     (ack),
    .mem_ce  (mem_ce),
    .mem_rw  (mem_rw),
    .addr_oe (addr_oe),
    .done    (done),
    .ld_a    (ctl.ld_a),
    .ld_b    (ctl.ld_b),
    .ld_c    (ctl.ld_c),
    .ld_d    (ctl.ld_d),
    .ld_m    (ctl.ld_m),
    .reg_a   (reg_a),
    .reg_b   (reg_b),
    .reg_c   (reg_c),
    .reg_d   (reg_d)
);

// File: tb/seqpath_top_bench.sv
module seqpath_top_bench;
    localparam int BW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          ack = 1'b0;
    logic [BW-1:0] din = '0;
    logic [BW-1:0] reg_a, reg_b, reg_c, reg_d, addr_bus;
    logic          flag_zero, flag_neg, flag_carry, mem_ce, mem_rw, addr_oe, done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit ended  = 1'b0;

    seqpath_top #(.W(BW)) u_seqpath_top (
        .clk(clk), .rst(rst), .start(start), .din(din), .ack(ack),
        .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c), .reg_d(reg_d),
        .flag_zero(flag_zero), .flag_neg(flag_neg), .flag_carry(flag_carry),
        .mem_ce(mem_ce), .mem_rw(mem_rw), .addr_oe(addr_oe),
        .addr_bus(addr_bus), .done(done)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
            finish_run();
        end
    end

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic run_one(input logic [BW-1:0] x, input logic [BW-1:0] y, input logic [BW-1:0] prev_a);
        logic [BW-1:0] s, fa, mar;
        logic [BW:0]   sum;
        bit            zp;
        int            n, waits;
        s   = y - x;
        zp  = ((s & x) == '0);
        fa  = zp ? ~s : s;
        mar = zp ? fa : x;
        din = x; start = 1'b1;
        step();
        start = 1'b0;
        // in LD1, after rising edge but before falling edge
        chk(reg_a == prev_a, "R3 A before fall", reg_a, prev_a);
        #10;
        chk(reg_a == x, "R3 A after fall", reg_a, x);
        #10;
        din = y;
        step();
        chk(reg_a == y && reg_b == x, "R4 parallel B<-oldA", reg_b, x);
        n = 0;
        while (!mem_ce && n < 10) begin
            step();
            n++;
        end
        chk(n == (zp ? 5 : 4), "R7 path length", n, zp ? 5 : 4);
        chk(mem_rw && addr_oe, "R8 strobes", {mem_rw, addr_oe}, 3);
        chk(addr_bus == mar, "R6 address source", addr_bus, mar);
        chk(reg_a == fa, "R1 sub/not result", reg_a, fa);
        chk(reg_c == x && reg_d == x, "R5 chain to D", reg_d, x);
        waits = (x + y) % 3;
        for (int i = 0; i < waits; i++) begin
            step();
            chk(mem_ce == 1'b1 && reg_a == fa, "R8 ack wait", mem_ce, 1);
        end
        ack = 1'b1;
        step();
        ack = 1'b0;
        chk(done == 1'b1 && mem_ce == 1'b0, "R11 done pulse", done, 1);
        step();
        chk(done == 1'b0, "R11 done one cycle", done, 0);
        chk(addr_oe == 1'b0, "R9 bus released", addr_oe, 0);
        sum = {1'b0, fa} + {1'b0, x};
        chk(flag_zero == (sum[BW-1:0] == '0), "R1 zero flag", flag_zero, sum[BW-1:0] == '0);
        chk(flag_neg == sum[BW-1], "R1 neg flag", flag_neg, sum[BW-1]);
        chk(flag_carry == sum[BW], "R1 carry flag", flag_carry, sum[BW]);
        step();
        step();
        chk(reg_a == fa && reg_b == x && reg_c == x && reg_d == x, "R2 idle hold", reg_a, fa);
    endtask

    initial begin
        logic [BW-1:0] last_a;
        repeat (3) step();
        rst = 1'b0;
        chk(reg_a == 0 && reg_b == 0 && reg_c == 0 && reg_d == 0, "R10 regs cleared", reg_a, 0);
        chk(!mem_ce && !mem_rw && !addr_oe && !done, "R10 idle strobes", {mem_ce, addr_oe, done}, 0);
        step();
        chk(reg_a == 0 && !done, "R10 no start stays idle", reg_a, 0);
        last_a = '0;
        for (int xi = 0; xi < (1 << BW); xi++) begin
            for (int yi = 0; yi < (1 << BW); yi++) begin
                logic [BW-1:0] xs, ys, sv;
                xs = BW'(xi);
                ys = BW'(yi);
                run_one(xs, ys, last_a);
                sv = ys - xs;
                last_a = ((sv & xs) == '0) ? ~sv : sv;
            end
        end
        finish_run();
    end
endmodule